// File: doc/BRIEF.md
# Aliased SIMD / Floating-Point Register File

This block holds eight 80-bit floating-point registers. The same storage also serves as eight 64-bit SIMD registers: the SIMD view has no storage of its own and maps each SIMD register onto the low 64 bits of the floating-point register with the same index. The SIMD view carries several packed data types, such as bytes, halfwords and words, in those same 64 bits. The register file only stores and moves bits, so the packed type does not change how it behaves.

There are four ports: one floating-point read port and one floating-point write port that carry full 80-bit values, and one SIMD read port and one SIMD write port that carry 64-bit values. Each port uses a 3-bit register address. A SIMD write replaces the low 64 bits of the shared register and sets its upper 16 bits to all ones. When both write ports target the same register in one cycle, the floating-point write takes effect. Both read ports are combinational and include a same-cycle bypass, so a read returns the value the register will hold after the current cycle's writes.

Top module: `alias_regfile`

## Requirements
- R1: After reset every register reads as zero on both read ports.
- R2: A floating-point write with `fp_we`=1 stores all 80 bits of `fp_wdata` into register `fp_waddr`. From the next cycle on, `fp_rdata` returns that value.
- R3: A SIMD write with `sm_we`=1 stores `sm_wdata` into bits 63:0 of register `sm_waddr` and sets bits 79:64 to 16'hFFFF.
- R4: `sm_rdata` always equals bits 63:0 of the floating-point view of register `sm_raddr`.
- R5: When both writes target the same register in one cycle, the register takes `fp_wdata` and the SIMD write has no effect.
- R6: When both writes target different registers in one cycle, both writes take effect.
- R7: A floating-point read of a register that is being written in the same cycle returns the new value. This holds whether the write comes from the floating-point port, the SIMD port, or both, and R5 decides which value wins.
- R8: A SIMD read of a register that is being written in the same cycle returns bits 63:0 of the new value.
- R9: A write changes only the register it addresses.
- R10: In a cycle with both write enables low, no register changes, whatever the write address and data inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fp_we | input | 1 | Floating-point write enable |
| fp_waddr | input | 3 | Floating-point write register index |
| fp_wdata | input | 80 | Floating-point write value |
| fp_raddr | input | 3 | Floating-point read register index |
| fp_rdata | output | 80 | Floating-point read value (bypassed) |
| sm_we | input | 1 | SIMD write enable |
| sm_waddr | input | 3 | SIMD write register index |
| sm_wdata | input | 64 | SIMD write value |
| sm_raddr | input | 3 | SIMD read register index |
| sm_rdata | output | 64 | SIMD read value (bypassed) |

## Verification
The only state is the contents of the registers. A wrong value written into a register therefore shows at the ports the first time that register is read, which can be in the very same cycle because the read path passes through the bypass. If the priority between the two writers is reversed, or the upper fill on a SIMD write is wrong, the floating-point read port shows it one cycle after the write, and the bypass shows it in the write cycle itself. Any mismatch between the two views shows at once when both read ports select the same index.

// File: rtl/arf_pkg.sv
package arf_pkg;

  typedef enum logic [1:0] {
    SRC_KEEP = 2'd0,
    SRC_FP   = 2'd1,
    SRC_SIMD = 2'd2
  } wsrc_e;

  // Floating-point writer has priority over the SIMD writer.
  function automatic wsrc_e pick_src(input logic fp_hit, input logic sm_hit);
    if (fp_hit)      return SRC_FP;
    else if (sm_hit) return SRC_SIMD;
    else             return SRC_KEEP;
  endfunction

endpackage

// File: rtl/arf_slot.sv
module arf_slot
  import arf_pkg::*;
#(
  parameter int FP_W   = 80,
  parameter int SIMD_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fp_hit,
  input  logic              sm_hit,
  input  logic [FP_W-1:0]   fp_wdata,
  input  logic [SIMD_W-1:0] sm_wdata,
  output logic [FP_W-1:0]   q,
  output logic [FP_W-1:0]   nxt
);
  localparam int FILL_W = FP_W - SIMD_W;

  wsrc_e src;
  assign src = pick_src(fp_hit, sm_hit);

  always_comb begin
    case (src)
      SRC_FP:   nxt = fp_wdata;
      SRC_SIMD: nxt = {{FILL_W{1'b1}}, sm_wdata};
      default:  nxt = q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

  AST_SLOT_FP_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    fp_hit |=> q == $past(fp_wdata)); // R5
  AST_SLOT_SIMD_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (sm_hit && !fp_hit) |=> q == {{FILL_W{1'b1}}, $past(sm_wdata)}); // R3
  AST_SLOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!sm_hit && !fp_hit) |=> $stable(q)); // R9

endmodule

// File: rtl/arf_read_port.sv
module arf_read_port #(
  parameter int NREG   = 8,
  parameter int W      = 80,
  parameter int ADDR_W = $clog2(NREG)
) (
  input  logic [NREG-1:0][W-1:0] src,
  input  logic [ADDR_W-1:0]      addr,
  output logic [W-1:0]           data
);
  always_comb begin
    data = '0;
    for (int i = 0; i < NREG; i++) begin
      if (addr == ADDR_W'(i)) data = src[i];
    end
  end
endmodule

// File: rtl/alias_regfile.sv
module alias_regfile #(
  parameter int NREG   = 8,
  parameter int FP_W   = 80,
  parameter int SIMD_W = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     fp_we,
  input  logic [$clog2(NREG)-1:0]  fp_waddr,
  input  logic [FP_W-1:0]          fp_wdata,
  input  logic [$clog2(NREG)-1:0]  fp_raddr,
  output logic [FP_W-1:0]          fp_rdata,
  input  logic                     sm_we,
  input  logic [$clog2(NREG)-1:0]  sm_waddr,
  input  logic [SIMD_W-1:0]        sm_wdata,
  input  logic [$clog2(NREG)-1:0]  sm_raddr,
  output logic [SIMD_W-1:0]        sm_rdata
);
  localparam int ADDR_W = $clog2(NREG);
  localparam int FILL_W = FP_W - SIMD_W;

  logic [NREG-1:0]              fp_hit;
  logic [NREG-1:0]              sm_hit;
  logic [NREG-1:0][FP_W-1:0]    cur_q;
  logic [NREG-1:0][FP_W-1:0]    nxt_v;
  logic [NREG-1:0][SIMD_W-1:0]  nxt_lo;
  logic                         wr_clash;

  assign wr_clash = fp_we && sm_we && (fp_waddr == sm_waddr);

  for (genvar g = 0; g < NREG; g++) begin : g_slot
    assign fp_hit[g] = fp_we && (fp_waddr == ADDR_W'(g));
    assign sm_hit[g] = sm_we && (sm_waddr == ADDR_W'(g));
    assign nxt_lo[g] = nxt_v[g][SIMD_W-1:0];

    arf_slot #(.FP_W(FP_W), .SIMD_W(SIMD_W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .fp_hit   (fp_hit[g]),
      .sm_hit   (sm_hit[g]),
      .fp_wdata (fp_wdata),
      .sm_wdata (sm_wdata),
      .q        (cur_q[g]),
      .nxt      (nxt_v[g])
    );
  end

  arf_read_port #(.NREG(NREG), .W(FP_W), .ADDR_W(ADDR_W)) u_fp_rd (
    .src  (nxt_v),
    .addr (fp_raddr),
    .data (fp_rdata)
  );

  arf_read_port #(.NREG(NREG), .W(SIMD_W), .ADDR_W(ADDR_W)) u_sm_rd (
    .src  (nxt_lo),
    .addr (sm_raddr),
    .data (sm_rdata)
  );

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> cur_q == '0); // R1
  AST_FP_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    fp_we |=> cur_q[$past(fp_waddr)] == $past(fp_wdata)); // R2
  AST_SIMD_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (sm_we && !wr_clash) |=> cur_q[$past(sm_waddr)][FP_W-1:SIMD_W] == {FILL_W{1'b1}}); // R3
  AST_VIEW_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
    (fp_raddr == sm_raddr) |-> sm_rdata == fp_rdata[SIMD_W-1:0]); // R4
  AST_CLASH_FP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clash |=> cur_q[$past(sm_waddr)] == $past(fp_wdata)); // R5
  AST_BYPASS_FP: assert property (@(posedge clk) disable iff (!rst_n)
    (fp_we && fp_raddr == fp_waddr) |-> fp_rdata == fp_wdata); // R7
  AST_BYPASS_SIMD: assert property (@(posedge clk) disable iff (!rst_n)
    (sm_we && !wr_clash && sm_raddr == sm_waddr) |-> sm_rdata == sm_wdata); // R8
  AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!fp_we && !sm_we) |=> $stable(cur_q)); // R10
  AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fp_hit) && $onehot0(sm_hit)); // R9

endmodule

// File: tb/tb_alias_regfile.sv
module tb_alias_regfile;
  localparam int NREG = 8;
  localparam int FP_W = 80;
  localparam int SM_W = 64;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            fp_we = 1'b0;
  logic [2:0]      fp_waddr = '0;
  logic [FP_W-1:0] fp_wdata = '0;
  logic [2:0]      fp_raddr = '0;
  logic [FP_W-1:0] fp_rdata;
  logic            sm_we = 1'b0;
  logic [2:0]      sm_waddr = '0;
  logic [SM_W-1:0] sm_wdata = '0;
  logic [2:0]      sm_raddr = '0;
  logic [SM_W-1:0] sm_rdata;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [FP_W-1:0] mdl [NREG];

  always #4 clk = ~clk;

  alias_regfile dut (
    .clk(clk), .rst_n(rst_n),
    .fp_we(fp_we), .fp_waddr(fp_waddr), .fp_wdata(fp_wdata),
    .fp_raddr(fp_raddr), .fp_rdata(fp_rdata),
    .sm_we(sm_we), .sm_waddr(sm_waddr), .sm_wdata(sm_wdata),
    .sm_raddr(sm_raddr), .sm_rdata(sm_rdata)
  );

  function automatic logic [FP_W-1:0] fpv(int i, int k);
    return {16'(16'h3F00 + i * 3 + k), 32'(32'hA500_0000 + i * 257), 32'(32'h5A00_0000 + k * 7 + i)};
  endfunction

  function automatic logic [SM_W-1:0] smv(int i, int k);
    return {32'(32'hC0DE_0000 + i), 32'(k * 16 + i + 1)};
  endfunction

  function automatic logic [FP_W-1:0] widen(logic [SM_W-1:0] d);
    return {16'hFFFF, d};
  endfunction

  task automatic cmp(string tag, logic [FP_W-1:0] got, logic [FP_W-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic check_all(string tag);
    for (int r = 0; r < NREG; r++) begin
      @(negedge clk);
      fp_raddr = 3'(r);
      sm_raddr = 3'(r);
      #1;
      cmp({tag, " fp"}, fp_rdata, mdl[r]);
      cmp({"R4 ", tag, " simd"}, {16'h0, sm_rdata}, {16'h0, mdl[r][SM_W-1:0]});
    end
  endtask

  // Apply one write cycle; model follows R2, R3, R5, R6.
  task automatic step(bit fwe, int fa, logic [FP_W-1:0] fd, bit swe, int sa, logic [SM_W-1:0] sd);
    @(negedge clk);
    fp_we = fwe; fp_waddr = 3'(fa); fp_wdata = fd;
    sm_we = swe; sm_waddr = 3'(sa); sm_wdata = sd;
    @(posedge clk);
    if (swe) mdl[sa] = widen(sd);
    if (fwe) mdl[fa] = fd;
    @(negedge clk);
    fp_we = 1'b0; sm_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < NREG; r++) mdl[r] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state
    check_all("R1");

    // R2: floating-point writes to every register
    for (int r = 0; r < NREG; r++) step(1, r, fpv(r, 0), 0, 0, '0);
    check_all("R2");

    // R3 / R9: SIMD writes to even registers, odd ones untouched
    for (int r = 0; r < NREG; r += 2) step(0, 0, '0, 1, r, smv(r, 1));
    check_all("R3 R9");

    // R5: both ports on the same register, FP wins
    for (int r = 0; r < NREG; r++) step(1, r, fpv(r, 2), 1, r, smv(r, 2));
    check_all("R5");

    // R6: both ports on different registers
    for (int r = 0; r < NREG; r++) step(1, r, fpv(r, 3), 1, (r + 3) % NREG, smv(r, 3));
    check_all("R6");

    // R7 / R8: same-cycle bypass on both read ports
    for (int r = 0; r < NREG; r++) begin
      for (int mode = 0; mode < 3; mode++) begin
        logic [FP_W-1:0] fd;
        logic [SM_W-1:0] sd;
        logic [FP_W-1:0] exp;
        fd = fpv(r, 4 + mode);
        sd = smv(r, 4 + mode);
        @(negedge clk);
        fp_we = (mode != 1); fp_waddr = 3'(r); fp_wdata = fd;
        sm_we = (mode != 0); sm_waddr = 3'(r); sm_wdata = sd;
        fp_raddr = 3'(r); sm_raddr = 3'(r);
        exp = (mode == 1) ? widen(sd) : fd;
        #1;
        cmp("R7 bypass fp", fp_rdata, exp);
        cmp("R8 bypass simd", {16'h0, sm_rdata}, {16'h0, exp[SM_W-1:0]});
        @(posedge clk);
        mdl[r] = exp;
        @(negedge clk);
        fp_we = 1'b0; sm_we = 1'b0;
      end
    end
    check_all("R7 R8 after");

    // R10: enables low, junk on address/data
    for (int r = 0; r < NREG; r++) begin
      @(negedge clk);
      fp_we = 1'b0; sm_we = 1'b0;
      fp_waddr = 3'(r); sm_waddr = 3'(NREG - 1 - r);
      fp_wdata = '1; sm_wdata = 64'hDEAD_BEEF_DEAD_BEEF;
      @(posedge clk);
    end
    check_all("R10");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule